// File: doc/BRIEF.md
# Multi-Converter Result Packer for DMA

This block gathers conversion results from two or three converters that run in lock-step and packs them into 32-bit words. The words go to one shared data output that a DMA engine drains through a valid/ready handshake. Each converter has its own result strobe and 16-bit result bus, and a small two-entry queue per converter holds results until the word that needs them can be built.

A 2-bit access mode chooses the packing. One mode sends one half-word per word. One sends two half-words per word. One sends two bytes per word. The fourth disables the block. With three converters the paired modes walk a fixed rotation of converter pairs. A result left over from one round is therefore paired with a result from the next round, rather than each round being packed on its own. A single data register faces the DMA. When a new word is ready while that register still holds an unconsumed word, the new word is dropped and a sticky overrun flag is raised.

The mode and the converter-count selection are meant to be changed only while the block is held in reset.

Top module: `dma_result_packer`

## Requirements
- R1: After reset `outValid` is 0 and `overrun` is 0.
- R2: With `accessMode` = 2'b00 the block is disabled. No word is produced, and result strobes are discarded rather than queued.
- R3: With `accessMode` = 2'b01 each word carries one result in bits 15:0, with bits 31:16 zero. Results leave in converter order 1, 2, 3 when three converters are used, and 1, 2 when two are used.
- R4: With `accessMode` = 2'b10 and three converters, each word carries two results. The pairs repeat in the order (2,1), (1,3), (3,2). The first-named converter's result goes in bits 31:16 and the second's in bits 15:0.
- R5: With `accessMode` = 2'b11 each word carries the low 8 bits of two results, using the same pair rotation as R4. The first-named converter goes in bits 15:8, the second in bits 7:0, and bits 31:16 are zero.
- R6: With `tripleEn` = 0 (two converters), every paired word is (2,1), and strobes on converter 3 are ignored.
- R7: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` does not change.
- R8: If a word becomes ready while the output holds an unaccepted word, the new word is dropped. `overrun` then goes to 1 and stays 1 until reset.
- R9: A word is emitted only once every result it needs has arrived. A result not used by the current word stays queued for a later word.
- R10: A word that becomes ready in the same cycle that the DMA accepts the previous word is loaded without loss and without setting `overrun`. This allows one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accessMode | input | 2 | Packing mode: 00 off, 01 half-word, 10 half-word pairs, 11 byte pairs |
| tripleEn | input | 1 | 1 = three converters, 0 = two converters |
| resValid | input | 3 | Per-converter result strobe; bit 0 is converter 1 |
| resData | input | 48 | Per-converter results; bits 15:0 are converter 1, 31:16 converter 2, 47:32 converter 3 |
| outData | output | 32 | Packed word toward DMA |
| outValid | output | 1 | Packed word is available |
| outReady | input | 1 | DMA accepts the word on a clock edge where both are 1 |
| overrun | output | 1 | Sticky: a packed word was dropped |

## Verification
Two events can fall on the same clock edge: a new packed word is loaded, and the DMA decides whether to take the word already held. In the half-word mode, one lock-step round with `outReady` held high makes three words leave on three consecutive edges. Each word is loaded on the edge where its predecessor is accepted. The bench checks that all three arrive in order and that `overrun` stays low. The same round with `outReady` held low must keep the first word intact, drop the other two and raise `overrun`. Releasing `outReady` afterwards must deliver only the first word.

// File: rtl/pack_pkg.sv
package pack_pkg;
  localparam int NUM_CONV = 3;
  localparam int SEL_W    = 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_HALF = 2'b01,
    MODE_PAIR = 2'b10,
    MODE_BYTE = 2'b11
  } accMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                flush;
    logic                load;
    logic [NUM_CONV-1:0] popMask;
    logic [SEL_W-1:0]    hiSel;
    logic [SEL_W-1:0]    loSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/pack_slot.sv
// Two-entry result queue for one converter.
module pack_slot #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic              avail,
  output logic [DATA_W-1:0] headData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] entry [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cntAfterPop;
  logic              doPop;
  logic              doPush;

  assign avail    = (cnt != '0);
  assign headData = entry[0];
  assign doPop    = pop && avail;
  assign cntAfterPop = cnt - CNT_W'(doPop);
  assign doPush   = push && (cntAfterPop < CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else begin
      if (doPop) begin
        for (int i = 0; i < DEPTH - 1; i++) entry[i] <= entry[i+1];
      end
      if (doPush) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (CNT_W'(i) == cntAfterPop) entry[i] <= pushData;
        end
      end
      cnt <= cntAfterPop + CNT_W'(doPush);
    end
  end
endmodule

// File: rtl/pack_ctrl.sv
// Step sequencer: picks which converters feed the next word.
module pack_ctrl
  import pack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          accessMode,
  input  logic                tripleEn,
  input  logic [NUM_CONV-1:0] avail,
  input  logic                outValid,
  input  logic                outReady,
  output ctrlStrobes_t        ctl,
  output logic                overrun
);
  accMode_e            mode;
  logic [1:0]          step;
  logic [1:0]          lastStep;
  logic [SEL_W-1:0]    hiSel;
  logic [SEL_W-1:0]    loSel;
  logic [NUM_CONV-1:0] need;
  logic                fire;
  logic                dropWord;

  assign mode = accMode_e'(accessMode);

  always_comb begin
    hiSel = 2'd0;
    loSel = 2'd0;
    if (mode == MODE_HALF) begin
      lastStep = tripleEn ? 2'd2 : 2'd1;
      hiSel    = step;
      loSel    = step;
    end else begin
      lastStep = tripleEn ? 2'd2 : 2'd0;
      // pair rotation (zero-based): (1,0) (0,2) (2,1)
      case (step)
        2'd1:    begin hiSel = 2'd0; loSel = 2'd2; end
        2'd2:    begin hiSel = 2'd2; loSel = 2'd1; end
        default: begin hiSel = 2'd1; loSel = 2'd0; end
      endcase
    end
    need     = (NUM_CONV'(1) << hiSel) | (NUM_CONV'(1) << loSel);
    fire     = (mode != MODE_OFF) && ((avail & need) == need);
    dropWord = fire && outValid && !outReady;

    ctl.flush   = (mode == MODE_OFF);
    ctl.load    = fire && !dropWord;
    ctl.popMask = fire ? need : '0;
    ctl.hiSel   = hiSel;
    ctl.loSel   = loSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step    <= 2'd0;
      overrun <= 1'b0;
    end else begin
      if (ctl.flush)  step <= 2'd0;
      else if (fire)  step <= (step >= lastStep) ? 2'd0 : step + 2'd1;
      if (dropWord)   overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/pack_datapath.sv
// Per-converter queues, word formatting and the output register.
module pack_datapath
  import pack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORD_W = 2 * DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 accessMode,
  input  logic                       tripleEn,
  input  logic [NUM_CONV-1:0]        resValid,
  input  logic [NUM_CONV*DATA_W-1:0] resData,
  input  ctrlStrobes_t               ctl,
  input  logic                       outReady,
  output logic [NUM_CONV-1:0]        avail,
  output logic [WORD_W-1:0]          outData,
  output logic                       outValid
);
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] heads [4];
  logic [DATA_W-1:0] hiData;
  logic [DATA_W-1:0] loData;
  logic [WORD_W-1:0] word;

  for (genvar g = 0; g < NUM_CONV; g++) begin : gSlot
    logic convEn;
    assign convEn = (g < 2) || tripleEn;
    pack_slot #(.DATA_W(DATA_W)) uSlot (
      .clk     (clk),
      .rstN    (rstN),
      .flush   (ctl.flush),
      .push    (resValid[g] && convEn && !ctl.flush),
      .pushData(resData[g*DATA_W +: DATA_W]),
      .pop     (ctl.popMask[g]),
      .avail   (avail[g]),
      .headData(heads[g])
    );
  end
  assign heads[3] = '0;

  assign hiData = heads[ctl.hiSel];
  assign loData = heads[ctl.loSel];

  always_comb begin
    case (accMode_e'(accessMode))
      MODE_PAIR: word = {hiData, loData};
      MODE_BYTE: word = {{(WORD_W-2*BYTE_W){1'b0}}, hiData[BYTE_W-1:0], loData[BYTE_W-1:0]};
      default:   word = {{(WORD_W-DATA_W){1'b0}}, loData};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (ctl.load) begin
      outValid <= 1'b1;
      outData  <= word;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_result_packer.sv
module dma_result_packer
  import pack_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [1:0]                 accessMode,
  input  logic                       tripleEn,
  input  logic [NUM_CONV-1:0]        resValid,
  input  logic [NUM_CONV*DATA_W-1:0] resData,
  output logic [WORD_W-1:0]          outData,
  output logic                       outValid,
  input  logic                       outReady,
  output logic                       overrun
);
  ctrlStrobes_t        ctl;
  logic [NUM_CONV-1:0] avail;

  pack_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .accessMode(accessMode), .tripleEn(tripleEn),
    .avail(avail), .outValid(outValid), .outReady(outReady),
    .ctl(ctl), .overrun(overrun)
  );

  pack_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .accessMode(accessMode), .tripleEn(tripleEn),
    .resValid(resValid), .resData(resData), .ctl(ctl), .outReady(outReady),
    .avail(avail), .outData(outData), .outValid(outValid)
  );
endmodule

// File: rtl/pack_checker.sv
module pack_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  accessMode,
  input logic [31:0] outData,
  input logic        outValid,
  input logic        outReady,
  input logic        overrun
);
  // R7: held word stays put until accepted
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8: overrun is sticky
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R8: overrun only rises when the output was blocked
  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(outValid && !outReady));

  // R2: disabled mode never starts a word
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accessMode == 2'b00 && !outValid) |=> !outValid);

  // R3, R5: single and byte modes leave the upper half clear
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && accessMode[0]) |-> (outData[31:16] == 16'h0));
endmodule

bind dma_result_packer pack_checker uChk (
  .clk(clk), .rstN(rstN), .accessMode(accessMode), .outData(outData),
  .outValid(outValid), .outReady(outReady), .overrun(overrun)
);

// File: tb/sim_dma_result_packer.sv
`timescale 1ns/100ps
module sim_dma_result_packer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  accessMode = 2'b00;
  logic        tripleEn = 1'b1;
  logic [2:0]  resValid = 3'b000;
  logic [47:0] resData = '0;
  logic [31:0] outData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] cap [16];
  int capCount = 0;

  always #2.5 clk = ~clk;

  dma_result_packer u0 (
    .clk(clk), .rstN(rstN), .accessMode(accessMode), .tripleEn(tripleEn),
    .resValid(resValid), .resData(resData), .outData(outData),
    .outValid(outValid), .outReady(outReady), .overrun(overrun)
  );

  // record every word the DMA accepts
  always @(negedge clk) begin
    if (!rstN) capCount = 0;
    else if (outValid && outReady && capCount < 16) begin
      cap[capCount] = outData;
      capCount = capCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic resetDut(input logic [1:0] m, input logic tri3);
    @(posedge clk); #1;
    rstN = 1'b0; accessMode = m; tripleEn = tri3; outReady = 1'b1; resValid = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic pushRound(input logic [15:0] d1, input logic [15:0] d2, input logic [15:0] d3, input logic [2:0] m);
    @(posedge clk); #1;
    resValid = m; resData = {d3, d2, d1};
    @(posedge clk); #1;
    resValid = '0;
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    resetDut(2'b01, 1'b1);
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", 32'(outValid), 32'h0);
    check(overrun == 1'b0, "R1 overrun after reset", 32'(overrun), 32'h0);
  endtask

  task automatic testHalfTriple();
    resetDut(2'b01, 1'b1);
    pushRound(16'h1111, 16'h2222, 16'h3333, 3'b111);
    settle();
    check(capCount == 3, "R3 word count", 32'(capCount), 32'd3);
    check(cap[0] == 32'h0000_1111, "R3 word 0", cap[0], 32'h0000_1111);
    check(cap[1] == 32'h0000_2222, "R3 word 1", cap[1], 32'h0000_2222);
    check(cap[2] == 32'h0000_3333, "R10 word 2 back-to-back", cap[2], 32'h0000_3333);
    check(overrun == 1'b0, "R10 no overrun on back-to-back", 32'(overrun), 32'h0);
  endtask

  task automatic testPairTriple();
    resetDut(2'b10, 1'b1);
    pushRound(16'h0A01, 16'h0A02, 16'h0A03, 3'b111);
    settle();
    check(capCount == 1, "R9 third result waits for a partner", 32'(capCount), 32'd1);
    pushRound(16'h0B01, 16'h0B02, 16'h0B03, 3'b111);
    settle();
    check(capCount == 3, "R4 word count", 32'(capCount), 32'd3);
    check(cap[0] == 32'h0A02_0A01, "R4 pair (2,1)", cap[0], 32'h0A02_0A01);
    check(cap[1] == 32'h0B01_0A03, "R4 pair (1,3)", cap[1], 32'h0B01_0A03);
    check(cap[2] == 32'h0B03_0B02, "R4 pair (3,2)", cap[2], 32'h0B03_0B02);
  endtask

  task automatic testByteTriple();
    resetDut(2'b11, 1'b1);
    pushRound(16'h1234, 16'h5678, 16'h9ABC, 3'b111);
    pushRound(16'h0F11, 16'h0F22, 16'h0F33, 3'b111);
    settle();
    check(capCount == 3, "R5 word count", 32'(capCount), 32'd3);
    check(cap[0] == 32'h0000_7834, "R5 bytes (2,1)", cap[0], 32'h0000_7834);
    check(cap[1] == 32'h0000_11BC, "R5 bytes (1,3)", cap[1], 32'h0000_11BC);
    check(cap[2] == 32'h0000_3322, "R5 bytes (3,2)", cap[2], 32'h0000_3322);
  endtask

  task automatic testDual();
    resetDut(2'b10, 1'b0);
    pushRound(16'hA001, 16'hA002, 16'hA003, 3'b111);
    pushRound(16'hB001, 16'hB002, 16'hB003, 3'b111);
    settle();
    check(capCount == 2, "R6 dual pair count", 32'(capCount), 32'd2);
    check(cap[0] == 32'hA002_A001, "R6 dual pair 0", cap[0], 32'hA002_A001);
    check(cap[1] == 32'hB002_B001, "R6 dual pair 1", cap[1], 32'hB002_B001);
    resetDut(2'b01, 1'b0);
    pushRound(16'hC001, 16'hC002, 16'hC003, 3'b111);
    settle();
    check(capCount == 2, "R6 dual half count", 32'(capCount), 32'd2);
    check(cap[1] == 32'h0000_C002, "R6 dual half order", cap[1], 32'h0000_C002);
  endtask

  task automatic testDisabled();
    resetDut(2'b00, 1'b1);
    pushRound(16'h1, 16'h2, 16'h3, 3'b111);
    settle();
    check(capCount == 0 && !outValid, "R2 disabled emits nothing", 32'(capCount), 32'd0);
  endtask

  task automatic testOverrun();
    resetDut(2'b01, 1'b1);
    outReady = 1'b0;
    pushRound(16'h4441, 16'h4442, 16'h4443, 3'b111);
    settle();
    check(outValid == 1'b1, "R7 word held while blocked", 32'(outValid), 32'h1);
    check(outData == 32'h0000_4441, "R7 held data", outData, 32'h0000_4441);
    check(overrun == 1'b1, "R8 overrun raised", 32'(overrun), 32'h1);
    outReady = 1'b1;
    settle();
    check(capCount == 1 && cap[0] == 32'h0000_4441, "R8 later words dropped", 32'(capCount), 32'd1);
    check(overrun == 1'b1, "R8 overrun sticky", 32'(overrun), 32'h1);
  endtask

  initial begin
    testReset();
    testHalfTriple();
    testPairTriple();
    testByteTriple();
    testDual();
    testDisabled();
    testOverrun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule